// File: doc/BRIEF.md
# Carry-Save Array Multiplier

This block multiplies two unsigned operands with purely combinational logic and produces the full double-width product. It uses no clock and holds no state. The default width is 8 bits, which gives a 16-bit product. The datapath is a regular grid of gate-level full adders. It has no behavioural multiply or add.

Each AND row is the multiplicand gated by one bit of the multiplier. These rows are reduced in carry-save form by `W-2` rows of `W` full adders. Each of these rows passes a sum vector and a carry vector to the row below it. A last row of `W` full adders resolves the remaining sum and carry vectors with a ripple chain. At the default width there are 7 rows of 8 adders.

After every row, the sum vector and the carry vector are brought out at their true bit weights in the product. This lets a checker inspect any intermediate stage directly.

Top module: `csm_array_mult`

## Requirements
- R1: For every pair of unsigned operands, `product_o` equals the arithmetic product `mcand_i * mplier_i`.
- R2: When either operand is zero, `product_o` is zero.
- R3: When one operand equals 1, `product_o` equals the other operand zero-extended to the product width.
- R4: When `mplier_i` has exactly one bit set, at position k, `product_o` equals `mcand_i` shifted left by k.
- R5: For carry-save row r (r = 0 .. W-3), the value `row_sum_o[r] + row_cry_o[r]`, plus the still-unabsorbed terms `mcand_i * mplier_i[m] * 2^m` for m = r+3 .. W-1, equals the product.
- R6: For carry-save row r, bits [r+1:0] of `row_sum_o[r]` already equal the same bits of `product_o`.
- R7: For carry-save row r, `row_sum_o[r]` is zero above bit r+W+1. `row_cry_o[r]` is zero outside bits [r+W+1:r+2].
- R8: The last entry `row_sum_o[W-2]` equals `product_o`. The last entry `row_cry_o[W-2]` holds the ripple carries at weights W .. 2W-1, and its bits [W-1:0] are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mcand_i | input | W (8) | Unsigned multiplicand |
| mplier_i | input | W (8) | Unsigned multiplier; bit j gates AND row j |
| product_o | output | 2W (16) | Unsigned product |
| row_sum_o | output | (W-1) x 2W (7 x 16) | Per-row sum vector at product weights; the last entry is the ripple result |
| row_cry_o | output | (W-1) x 2W (7 x 16) | Per-row carry vector at product weights; the last entry is the ripple carries |

## Verification
The hardest case to reach is a carry that travels the whole ripple row while every carry-save row is also saturated. This happens only when both operands are dense in ones near their top bits, for example all-ones times all-ones.

The stimulus reaches this case by sweeping the complete operand space in a seeded, scrambled order. The sweep is preceded by directed corners and random pairs. At every point, the bench checks each intermediate row against the arithmetic invariant it must satisfy (R5), not only the final product. A fault inside a carry-save row therefore shows up even when it happens to cancel in the product.

// File: rtl/csm_pkg.sv
package csm_pkg;
  // Default operand width of the array multiplier.
  localparam int unsigned CSM_W = 8;
endpackage

// File: rtl/csm_fa.sv
module csm_fa (
  input  logic a_i,
  input  logic b_i,
  input  logic c_i,
  output logic s_o,
  output logic c_o
);
  logic ab_x;
  assign ab_x = a_i ^ b_i;
  assign s_o  = ab_x ^ c_i;
  assign c_o  = (a_i & b_i) | (c_i & ab_x);
endmodule

// File: rtl/csm_csa_row.sv
module csm_csa_row #(
  parameter int unsigned W = csm_pkg::CSM_W
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  logic [W-1:0] z_i,
  output logic [W-1:0] sum_o,
  output logic [W-1:0] cry_o
);
  for (genvar k = 0; k < W; k++) begin : g_col
    csm_fa u_fa (
      .a_i(x_i[k]),
      .b_i(y_i[k]),
      .c_i(z_i[k]),
      .s_o(sum_o[k]),
      .c_o(cry_o[k])
    );

    always_comb begin
      // R1
      csa_count_chk: assert ({cry_o[k], sum_o[k]} == 2'($countones({x_i[k], y_i[k], z_i[k]})))
        else $error("carry-save column %0d miscounts its inputs", k);
    end
  end
endmodule

// File: rtl/csm_ripple_row.sv
module csm_ripple_row #(
  parameter int unsigned W = csm_pkg::CSM_W
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  output logic [W-1:0] sum_o,
  output logic [W-1:0] cry_o
);
  logic [W-1:0] cin;

  for (genvar k = 0; k < W; k++) begin : g_col
    if (k == 0) begin : g_lsb
      assign cin[k] = 1'b0;
    end else begin : g_up
      assign cin[k] = cry_o[k-1];
    end

    csm_fa u_fa (
      .a_i(x_i[k]),
      .b_i(y_i[k]),
      .c_i(cin[k]),
      .s_o(sum_o[k]),
      .c_o(cry_o[k])
    );

    always_comb begin
      // R1
      ripple_count_chk: assert ({cry_o[k], sum_o[k]} == 2'($countones({x_i[k], y_i[k], cin[k]})))
        else $error("ripple column %0d miscounts its inputs", k);
    end
  end
endmodule

// File: rtl/csm_array_mult.sv
module csm_array_mult #(
  parameter int unsigned W = csm_pkg::CSM_W
) (
  input  logic [W-1:0]            mcand_i,
  input  logic [W-1:0]            mplier_i,
  output logic [2*W-1:0]          product_o,
  output logic [W-2:0][2*W-1:0]   row_sum_o,
  output logic [W-2:0][2*W-1:0]   row_cry_o
);
  localparam int unsigned PW   = 2 * W;
  localparam int unsigned NCSA = W - 2;

  // AND rows: pp[j][i] = mcand_i[i] & mplier_i[j]
  logic [W-1:0][W-1:0] pp;
  for (genvar j = 0; j < W; j++) begin : g_and
    assign pp[j] = mcand_i & {W{mplier_i[j]}};
  end

  // Vectors entering carry-save row j (j = 1 .. NCSA) and the ripple row (j = W-1)
  logic [W-1:1][W-1:0] sv;
  logic [W-1:1][W-1:0] cv;
  // Settled low product bits
  logic [W-2:0]        fin;

  assign sv[1]  = {1'b0, pp[0][W-1:1]};
  assign cv[1]  = pp[1];
  assign fin[0] = pp[0][0];

  for (genvar j = 1; j <= NCSA; j++) begin : g_csa
    logic [W-1:0]  zv;
    logic [W-1:0]  rs;
    logic [W-1:0]  rc;
    logic [PW-1:0] sum_vec;
    logic [PW-1:0] cry_vec;

    assign zv = {pp[j+1][W-2:0], 1'b0};

    csm_csa_row #(.W(W)) u_row (
      .x_i  (sv[j]),
      .y_i  (cv[j]),
      .z_i  (zv),
      .sum_o(rs),
      .cry_o(rc)
    );

    assign sv[j+1] = {pp[j+1][W-1], rs[W-1:1]};
    assign cv[j+1] = rc;
    assign fin[j]  = rs[0];

    always_comb begin
      sum_vec = '0;
      for (int k = 0; k < j; k++) sum_vec[k] = fin[k];
      for (int k = 0; k < W; k++) sum_vec[j+k] = rs[k];
      sum_vec[j+W] = pp[j+1][W-1];
    end

    always_comb begin
      cry_vec = '0;
      for (int k = 0; k < W; k++) cry_vec[j+1+k] = rc[k];
    end

    assign row_sum_o[j-1] = sum_vec;
    assign row_cry_o[j-1] = cry_vec;
  end

  // Final row: ripple resolution of the last sum/carry pair
  logic [W-1:0] fsum;
  logic [W-1:0] fcry;

  csm_ripple_row #(.W(W)) u_final (
    .x_i  (sv[W-1]),
    .y_i  (cv[W-1]),
    .sum_o(fsum),
    .cry_o(fcry)
  );

  assign product_o      = {fcry[W-1], fsum, fin};
  assign row_sum_o[W-2] = product_o;
  assign row_cry_o[W-2] = {fcry, {W{1'b0}}};

  always_comb begin
    // R2
    zero_operand_chk: assert (!((mcand_i == '0) || (mplier_i == '0)) || (product_o == '0))
      else $error("zero operand gave nonzero product %0h", product_o);
    // R3
    unit_operand_chk: assert (!(mplier_i == W'(1)) || (product_o == PW'(mcand_i)))
      else $error("unit multiplier gave %0h", product_o);
  end

  always_comb begin
    int unsigned sh;
    sh = 0;
    for (int k = 0; k < W; k++) if (mplier_i[k]) sh = k;
    // R4
    pow2_operand_chk: assert (!$onehot(mplier_i) || (product_o == (PW'(mcand_i) << sh)))
      else $error("power-of-two multiplier gave %0h", product_o);
  end
endmodule

// File: tb/tb_csm_array_mult.sv
`timescale 1ns/1ps
module tb_csm_array_mult;
  localparam int W  = 8;
  localparam int PW = 2 * W;

  logic clk;
  logic rst_n;
  logic [W-1:0]          a;
  logic [W-1:0]          b;
  logic [PW-1:0]         prod;
  logic [W-2:0][PW-1:0]  rsum;
  logic [W-2:0][PW-1:0]  rcry;

  int  checks   = 0;
  int  failures = 0;
  bit  finished = 0;

  csm_array_mult #(.W(W)) dut (
    .mcand_i  (a),
    .mplier_i (b),
    .product_o(prod),
    .row_sum_o(rsum),
    .row_cry_o(rcry)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic int ref_prod(int x, int y);
    return x * y;
  endfunction

  // Terms m = r+3 .. W-1 not yet absorbed after carry-save row r
  function automatic int ref_pending(int x, int y, int r);
    int acc = 0;
    for (int m = r + 3; m < W; m++) if (y[m]) acc = acc + (x << m);
    return acc;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s a=%0d b=%0d actual=%0h expected=%0h", req, a, b, act, exp);
    end
  endtask

  task automatic apply(int x, int y);
    @(posedge clk);
    a = x[W-1:0];
    b = y[W-1:0];
    @(negedge clk);
  endtask

  task automatic full_check();
    int p = ref_prod(int'(a), int'(b));
    check(int'(prod) == p, "R1", int'(prod), p);
    for (int r = 0; r < W - 2; r++) begin
      int tot  = int'(rsum[r]) + int'(rcry[r]) + ref_pending(int'(a), int'(b), r);
      int lmsk = (1 << (r + 2)) - 1;
      int smsk = (1 << (r + W + 2)) - 1;
      int cmsk = smsk & ~((1 << (r + 2)) - 1);
      check(tot == p, "R5", tot, p);
      check((int'(rsum[r]) & lmsk) == (p & lmsk), "R6", int'(rsum[r]) & lmsk, p & lmsk);
      check((int'(rsum[r]) & ~smsk) == 0, "R7", int'(rsum[r]), int'(rsum[r]) & smsk);
      check((int'(rcry[r]) & ~cmsk) == 0, "R7", int'(rcry[r]), int'(rcry[r]) & cmsk);
    end
    check(int'(rsum[W-2]) == p, "R8", int'(rsum[W-2]), p);
    check(int'(rcry[W-2][W-1:0]) == 0, "R8", int'(rcry[W-2][W-1:0]), 0);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
      summary();
      $finish;
    end
  end

  initial begin
    int mask_a;
    int mask_b;
    a = '0;
    b = '0;
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // Initial state with zero operands: R2
    check(prod == '0, "R2", int'(prod), 0);

    // Zero operands: R2
    apply(0, 0);     check(prod == '0, "R2", int'(prod), 0);
    apply(0, 255);   check(prod == '0, "R2", int'(prod), 0);
    apply(173, 0);   check(prod == '0, "R2", int'(prod), 0);

    // Unit operands: R3
    apply(173, 1);   check(int'(prod) == 173, "R3", int'(prod), 173);
    apply(1, 201);   check(int'(prod) == 201, "R3", int'(prod), 201);
    apply(255, 1);   check(int'(prod) == 255, "R3", int'(prod), 255);

    // Power-of-two multipliers: R4
    for (int k = 0; k < W; k++) begin
      apply(255, 1 << k);
      check(int'(prod) == (255 << k), "R4", int'(prod), 255 << k);
      apply(93, 1 << k);
      check(int'(prod) == (93 << k), "R4", int'(prod), 93 << k);
    end

    // Dense corners with long carry chains: R1, R5-R8
    apply(255, 255); full_check();
    apply(128, 128); full_check();
    apply(255, 128); full_check();
    apply(170, 85);  full_check();

    // Seeded random pairs
    void'($urandom(32'h5EED_0C5A));
    for (int n = 0; n < 3000; n++) begin
      apply(int'($urandom_range(255)), int'($urandom_range(255)));
      full_check();
    end

    // Exhaustive sweep in scrambled order: every pair exactly once
    mask_a = int'($urandom_range(255));
    mask_b = int'($urandom_range(255));
    for (int i = 0; i < 65536; i++) begin
      apply((i & 255) ^ mask_a, (i >> 8) ^ mask_b);
      full_check();
    end

    finished = 1;
    summary();
    $finish;
  end
endmodule